// File: doc/BRIEF.md
# Flat Panel Power Sequencer

This block turns a flat-panel display on and off in a safe order. It drives three enables: the panel logic supply, the panel data and control signals, and the backlight (or VEE) supply. Power-up raises them in that order, and power-down drops them in the reverse order. Two programmable waits separate the steps. Each wait is a short or a long number of reference-clock ticks, which correspond to 32 ms and 128 ms of a reference clock of about 14.3 MHz. A divider outside the block supplies the tick as a one-cycle strobe.

A control register outside the block feeds the other inputs:
- a power request,
- one short/long select for each of the two waits,
- a mode bit that bypasses the timed sequence and lets an external sequencer decide, with all three enables following the request directly,
- a source select for the active-low display-off output. This output either tracks the backlight enable or follows a separate blanking bit, so the backlight can be shut off while the panel stays powered.

A two-bit status shows whether the panel is off, fully on, or part-way through a sequence.

Top module: `fp_power_seq`

## Requirements
- R1: At every cycle `data_en` high implies `vdd_en` high, and `bkl_en` high implies `data_en` high.
- R2: In timed mode (`ext_seq`=0), with the panel fully off, a clock edge that samples `pwr_req`=1 raises `vdd_en` at that edge, with `data_en` and `bkl_en` still low.
- R3: In timed mode, once `vdd_en` has risen, `data_en` rises on the clock edge after the edge that samples the N-th `ref_tick` of the phase. N is SHORT_TICKS when `supply_dly_long`=0 and LONG_TICKS when it is 1.
- R4: In timed mode, once `data_en` has risen, `bkl_en` rises in the same way after N ticks. Here N is chosen by `light_dly_long` (0 gives SHORT_TICKS, 1 gives LONG_TICKS).
- R5: In timed mode, `pwr_req`=0 from fully on drops `bkl_en` at the next edge. `data_en` then drops after the wait chosen by `light_dly_long`, and `vdd_en` drops after a further wait chosen by `supply_dly_long`.
- R6: Reversing `pwr_req` during a sequence starts the opposite sequence from the current step. No enable changes at the reversal edge except the backlight, and a full wait for the step is restarted.
- R7: A delay select is sampled only on the edge where its phase begins. Changing it later in the phase does not change that phase's length.
- R8: With `ext_seq`=1, all three enables equal the `pwr_req` sampled at the previous edge. No wait applies and `ref_tick` has no effect.
- R9: With `blank_src`=0, `disp_off_n` equals `bkl_en` (low = display off). With `blank_src`=1, it equals the inverse of `blank_req` sampled at the previous edge, and `blank_req` has no effect while `blank_src`=0.
- R10: `status` is 2'b00 when all enables are off and idle, 2'b10 when fully on, and 2'b01 during any sequence; 2'b11 never appears.
- R11: While `rst_n` is low, all enables are 0, `disp_off_n` is 0 and `status` is 2'b00. After release the block idles off until requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle timebase strobe from the reference divider |
| pwr_req | input | 1 | Requested panel state: 1 on, 0 off |
| ext_seq | input | 1 | 1 bypasses the timed sequence |
| supply_dly_long | input | 1 | Wait between supply and data: 0 short, 1 long |
| light_dly_long | input | 1 | Wait between data and backlight: 0 short, 1 long |
| blank_src | input | 1 | Display-off source: 0 sequence, 1 `blank_req` |
| blank_req | input | 1 | Separate blanking control, 1 blanks |
| vdd_en | output | 1 | Panel logic supply enable |
| data_en | output | 1 | Panel data and control signal enable |
| bkl_en | output | 1 | Backlight / VEE enable |
| disp_off_n | output | 1 | Active-low display-off |
| status | output | 2 | 00 off, 01 sequencing, 10 on |

## Verification
Every output is a register loaded from the next-state logic, so a level change on `pwr_req`, `ext_seq`, `blank_src` or `blank_req` shows at the ports one edge after it is sampled. A timed step shows one edge after the edge that consumes its final tick. The bench drives all inputs on the falling edge and reads the outputs on a later falling edge. Before each compare it advances exactly the number of ticks or idle clocks that the requirement predicts. For every wait it checks the enable one tick short of the count, with idle clocks added, and again just after the final tick, so a phase that is one tick early or late is caught.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [2:0] {
        ST_OFF         = 3'd0,
        ST_RAMP_SUPPLY = 3'd1,
        ST_RAMP_DATA   = 3'd2,
        ST_ON          = 3'd3,
        ST_FALL_LIGHT  = 3'd4,
        ST_FALL_DATA   = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        PS_DOWN = 2'b00,
        PS_BUSY = 2'b01,
        PS_UP   = 2'b10
    } pwr_status_e;

    typedef struct packed {
        seq_state_e  st;
        logic        vdd;
        logic        data;
        logic        bkl;
        logic        disp_n;
        pwr_status_e stat;
    } core_regs_t;

    // enables held in each step: {supply, data, backlight}
    function automatic logic [2:0] step_enables(seq_state_e s);
        case (s)
            ST_RAMP_SUPPLY, ST_FALL_DATA: return 3'b100;
            ST_RAMP_DATA,   ST_FALL_LIGHT: return 3'b110;
            ST_ON:                         return 3'b111;
            default:                       return 3'b000;
        endcase
    endfunction

    function automatic pwr_status_e step_status(seq_state_e s);
        case (s)
            ST_OFF:  return PS_DOWN;
            ST_ON:   return PS_UP;
            default: return PS_BUSY;
        endcase
    endfunction

endpackage

// File: rtl/fps_phase_timer.sv
module fps_phase_timer #(
    parameter int unsigned SHORT_TICKS = 4,
    parameter int unsigned LONG_TICKS  = 16,
    parameter int unsigned CNT_W       = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_long,
    input  logic tick,
    output logic expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_long ? CNT_W'(LONG_TICKS) : CNT_W'(SHORT_TICKS);
        end else if (tick && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/fps_seq_core.sv
module fps_seq_core
    import fps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_req,
    input  logic       ext_seq,
    input  logic       sel_supply_long,
    input  logic       sel_light_long,
    input  logic       blank_src,
    input  logic       blank_req,
    input  logic       phase_done,
    output logic       ld,
    output logic       ld_long,
    output logic       vdd_en,
    output logic       data_en,
    output logic       bkl_en,
    output logic       disp_off_n,
    output logic [1:0] status
);

    core_regs_t r_d, r_q;
    logic [2:0] en_d;

    always_comb begin
        r_d     = r_q;
        ld      = 1'b0;
        ld_long = 1'b0;
        if (ext_seq) begin
            r_d.st = pwr_req ? ST_ON : ST_OFF;
        end else begin
            case (r_q.st)
                ST_OFF: begin
                    if (pwr_req) begin
                        r_d.st = ST_RAMP_SUPPLY; ld = 1'b1; ld_long = sel_supply_long;
                    end
                end
                ST_RAMP_SUPPLY: begin
                    if (!pwr_req) begin
                        r_d.st = ST_FALL_DATA; ld = 1'b1; ld_long = sel_supply_long;
                    end else if (phase_done) begin
                        r_d.st = ST_RAMP_DATA; ld = 1'b1; ld_long = sel_light_long;
                    end
                end
                ST_RAMP_DATA: begin
                    if (!pwr_req) begin
                        r_d.st = ST_FALL_LIGHT; ld = 1'b1; ld_long = sel_light_long;
                    end else if (phase_done) begin
                        r_d.st = ST_ON;
                    end
                end
                ST_ON: begin
                    if (!pwr_req) begin
                        r_d.st = ST_FALL_LIGHT; ld = 1'b1; ld_long = sel_light_long;
                    end
                end
                ST_FALL_LIGHT: begin
                    if (pwr_req) begin
                        r_d.st = ST_RAMP_DATA; ld = 1'b1; ld_long = sel_light_long;
                    end else if (phase_done) begin
                        r_d.st = ST_FALL_DATA; ld = 1'b1; ld_long = sel_supply_long;
                    end
                end
                ST_FALL_DATA: begin
                    if (pwr_req) begin
                        r_d.st = ST_RAMP_SUPPLY; ld = 1'b1; ld_long = sel_supply_long;
                    end else if (phase_done) begin
                        r_d.st = ST_OFF;
                    end
                end
                default: r_d.st = ST_OFF;
            endcase
        end
        en_d       = step_enables(r_d.st);
        r_d.vdd    = en_d[2];
        r_d.data   = en_d[1];
        r_d.bkl    = en_d[0];
        r_d.disp_n = blank_src ? ~blank_req : en_d[0];
        r_d.stat   = step_status(r_d.st);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_OFF, vdd: 1'b0, data: 1'b0, bkl: 1'b0,
                     disp_n: 1'b0, stat: PS_DOWN};
        end else begin
            r_q <= r_d;
        end
    end

    assign vdd_en     = r_q.vdd;
    assign data_en    = r_q.data;
    assign bkl_en     = r_q.bkl;
    assign disp_off_n = r_q.disp_n;
    assign status     = r_q.stat;

endmodule

// File: rtl/fp_power_seq.sv
module fp_power_seq #(
    parameter int unsigned REF_HZ      = 14318180,
    parameter int unsigned SHORT_MS    = 32,
    parameter int unsigned LONG_MS     = 128,
    parameter int unsigned SHORT_TICKS = (REF_HZ / 1000) * SHORT_MS,
    parameter int unsigned LONG_TICKS  = (REF_HZ / 1000) * LONG_MS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       pwr_req,
    input  logic       ext_seq,
    input  logic       supply_dly_long,
    input  logic       light_dly_long,
    input  logic       blank_src,
    input  logic       blank_req,
    output logic       vdd_en,
    output logic       data_en,
    output logic       bkl_en,
    output logic       disp_off_n,
    output logic [1:0] status
);

    localparam int unsigned MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

    logic ld, ld_long, phase_done;

    fps_phase_timer #(
        .SHORT_TICKS(SHORT_TICKS),
        .LONG_TICKS (LONG_TICKS),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_long(ld_long),
        .tick     (ref_tick),
        .expired  (phase_done)
    );

    fps_seq_core u_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .pwr_req        (pwr_req),
        .ext_seq        (ext_seq),
        .sel_supply_long(supply_dly_long),
        .sel_light_long (light_dly_long),
        .blank_src      (blank_src),
        .blank_req      (blank_req),
        .phase_done     (phase_done),
        .ld             (ld),
        .ld_long        (ld_long),
        .vdd_en         (vdd_en),
        .data_en        (data_en),
        .bkl_en         (bkl_en),
        .disp_off_n     (disp_off_n),
        .status         (status)
    );

endmodule

// File: rtl/fp_power_seq_chk.sv
module fp_power_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_req,
    input logic       ext_seq,
    input logic       blank_src,
    input logic       blank_req,
    input logic       vdd_en,
    input logic       data_en,
    input logic       bkl_en,
    input logic       disp_off_n,
    input logic [1:0] status
);

    AST_DATA_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        data_en |-> vdd_en); // R1
    AST_LIGHT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        bkl_en |-> data_en); // R1
    AST_START_FROM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b00 && pwr_req && !ext_seq) |=> (vdd_en && !data_en)); // R2
    AST_DATA_AFTER_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(data_en) && !$past(ext_seq)) |-> $past(vdd_en)); // R3
    AST_SUPPLY_DROPS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(vdd_en) && !$past(ext_seq)) |-> !$past(data_en)); // R5
    AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ext_seq |=> (vdd_en == $past(pwr_req) && bkl_en == $past(pwr_req))); // R8
    AST_BLANK_TRACKS_LIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_src |=> (disp_off_n == bkl_en)); // R9
    AST_BLANK_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
        blank_src |=> (disp_off_n == !$past(blank_req))); // R9
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11); // R10
    AST_STATUS_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b10) |-> (vdd_en && data_en && bkl_en)); // R10
    AST_STATUS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b00) |-> (!vdd_en && !data_en && !bkl_en)); // R10
    AST_RESET_OFF: assert property (@(posedge clk)
        $past(!rst_n) |-> (!vdd_en && !disp_off_n && status == 2'b00)); // R11

endmodule

bind fp_power_seq fp_power_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_req   (pwr_req),
    .ext_seq   (ext_seq),
    .blank_src (blank_src),
    .blank_req (blank_req),
    .vdd_en    (vdd_en),
    .data_en   (data_en),
    .bkl_en    (bkl_en),
    .disp_off_n(disp_off_n),
    .status    (status)
);

// File: tb/fp_power_seq_test.sv
module fp_power_seq_test;

    localparam int unsigned SHORT_T = 3;
    localparam int unsigned LONG_T  = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0, pwr_req = 1'b0, ext_seq = 1'b0;
    logic supply_dly_long = 1'b0, light_dly_long = 1'b0;
    logic blank_src = 1'b0, blank_req = 1'b0;
    logic vdd_en, data_en, bkl_en, disp_off_n;
    logic [1:0] status;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2ns clk = ~clk;

    fp_power_seq #(.SHORT_TICKS(SHORT_T), .LONG_TICKS(LONG_T)) uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pwr_req(pwr_req),
        .ext_seq(ext_seq), .supply_dly_long(supply_dly_long),
        .light_dly_long(light_dly_long), .blank_src(blank_src),
        .blank_req(blank_req), .vdd_en(vdd_en), .data_en(data_en),
        .bkl_en(bkl_en), .disp_off_n(disp_off_n), .status(status)
    );

    // {ext_seq, pwr_req, blank_src, blank_req} -> {vdd, data, bkl, disp_off_n, status}
    localparam logic [9:0] VEC [8] = '{
        {4'b1100, 6'b111110},
        {4'b1111, 6'b111010},
        {4'b1110, 6'b111110},
        {4'b1010, 6'b000100},
        {4'b1000, 6'b000000},
        {4'b1001, 6'b000000},
        {4'b1101, 6'b111110},
        {4'b1000, 6'b000000}
    };

    function automatic logic [5:0] outs();
        return {vdd_en, data_en, bkl_en, disp_off_n, status};
    endfunction

    task automatic check(string req, logic [5:0] act, logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(int n);
        repeat (n) begin
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        step(3);
        check("R11 in reset", outs(), 6'b000000);
        rst_n = 1'b1;
        step(2);
        check("R11 after release", outs(), 6'b000000);

        // bypass mode and display-off source vectors
        for (int i = 0; i < 8; i++) begin
            {ext_seq, pwr_req, blank_src, blank_req} = VEC[i][9:6];
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
            check("R8 R9 vector", outs(), VEC[i][5:0]);
        end
        ext_seq = 1'b0;
        step(1);

        // timed power-up: short supply wait, long light wait
        supply_dly_long = 1'b0;
        light_dly_long  = 1'b1;
        pwr_req = 1'b1;
        step(1);
        check("R2 supply first", outs(), 6'b100001);
        ticks(SHORT_T - 1); step(3);
        check("R3 data held one tick short", outs(), 6'b100001);
        ticks(1);
        check("R3 data on after short wait", outs(), 6'b110001);
        ticks(LONG_T - 1); step(2);
        check("R4 light held one tick short", outs(), 6'b110001);
        ticks(1);
        check("R4 R9 R10 fully on", outs(), 6'b111110);
        ticks(3);
        check("R10 on is stable", outs(), 6'b111110);

        // timed power-down with same selects
        pwr_req = 1'b0;
        step(1);
        check("R5 light off first", outs(), 6'b110001);
        ticks(LONG_T - 1); step(2);
        check("R5 data held one tick short", outs(), 6'b110001);
        ticks(1);
        check("R5 data off after long wait", outs(), 6'b100001);
        ticks(SHORT_T - 1);
        check("R5 supply held one tick short", outs(), 6'b100001);
        ticks(1);
        check("R5 R10 supply off", outs(), 6'b000000);

        // select sampled at phase start
        supply_dly_long = 1'b1;
        pwr_req = 1'b1;
        step(1);
        check("R7 supply on", outs(), 6'b100001);
        supply_dly_long = 1'b0;
        ticks(SHORT_T); step(2);
        check("R7 late select ignored", outs(), 6'b100001);
        ticks(LONG_T - SHORT_T - 1);
        check("R7 still long", outs(), 6'b100001);
        ticks(1);
        check("R7 long wait honoured", outs(), 6'b110001);

        // reversal mid-sequence
        light_dly_long = 1'b0;
        pwr_req = 1'b0;
        step(1);
        check("R6 reverse keeps data", outs(), 6'b110001);
        ticks(SHORT_T - 1);
        check("R6 data wait restarted", outs(), 6'b110001);
        ticks(1);
        check("R6 data off", outs(), 6'b100001);
        pwr_req = 1'b1;
        step(1);
        check("R6 reverse keeps supply", outs(), 6'b100001);
        ticks(SHORT_T);
        check("R6 data back on", outs(), 6'b110001);

        // bypass entered mid-sequence, ticks ignored
        ext_seq = 1'b1;
        pwr_req = 1'b0;
        step(1);
        check("R8 bypass off", outs(), 6'b000000);
        pwr_req = 1'b1;
        step(1);
        check("R8 bypass on", outs(), 6'b111110);
        ticks(LONG_T);
        check("R8 ticks ignored", outs(), 6'b111110);

        // reset while on
        rst_n = 1'b0;
        step(1);
        check("R11 reset while on", outs(), 6'b000000);
        rst_n = 1'b1;
        ext_seq = 1'b0;
        pwr_req = 1'b0;
        step(2);
        check("R11 idle after reset", outs(), 6'b000000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #400us;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule